// File: doc/BRIEF.md
# Block sequence number stream source

This block produces the framing stream that paces a streaming datapath. While running it drives a valid strobe on every clock, cuts the stream into blocks of a fixed number of clocks (start-of-block on the first clock, end-of-block on the last), and numbers each block with a 64-bit block sequence number (BSN) that increments once per block. A sync flag marks selected block starts, one per configured sync period, so that downstream stages can align to a common time grid.

Software controls the source through a small word-addressed register port. It can start the stream at once or arm it to start a programmable number of clocks after the next rising edge of a pulse-per-second input. It can also stop the stream, set the sync period in clocks, and load the BSN that the first block carries. Readback returns the BSN that was captured at the most recent sync, so any read inside a sync interval gives the number at the start of that interval. Register writes reach the stream logic through a modelled clock-domain transfer with a fixed latency of `XFER_LAT` clocks. One write starts the countdown, and any later write restarts it. When the countdown expires, all staged values move across together.

Top module: `bsn_stream_src`

## Requirements
- R1: After reset st_valid, st_sob, st_eob and st_sync are low, word 0 reads 0, word 1 reads SYNC_CLKS_DEF, and words 2, 3 and 4 read 0.
- R2: Writing 1 to word 0 starts the stream exactly XFER_LAT clocks after the write is sampled. The first clock of the stream has st_valid, st_sob and st_sync high and carries the loaded BSN. st_valid then stays high on every clock.
- R3: Each block lasts BLK_CLKS clocks. st_sob is high on its first clock and st_eob on its last. st_bsn holds its value inside a block and rises by one from each block to the next, with the carry passing from bit 31 into bit 32.
- R4: Word 1 sets the sync period in clocks, counted from the start of the stream. When the period is a multiple of BLK_CLKS, consecutive syncs differ in BSN by period/BLK_CLKS.
- R5: When the period is not a multiple of BLK_CLKS, st_sync is high on the first start-of-block at or after each multiple of the period.
- R6: A write to word 2 only stages the low 32 BSN bits, and a following start still uses the previously committed BSN. A write to word 3 commits {word 3 data, staged low word} as the initial BSN.
- R7: Words 2 and 3 return the low and high halves of the BSN captured at the most recent sync. Read data appears on reg_rdata one clock after reg_rd is sampled.
- R8: Writing 2 to word 0 arms the source. It starts when a rising edge of pps has been sampled plus the word 4 offset in clocks. If no rising edge arrives, there is no output.
- R9: Word 0 reads {running in bit 2, active mode in bits 1:0 (0 off, 1 immediate, 2 at pps)}. Words 1 and 4 read back the values last written.
- R10: Writing 0 to word 0 drops st_valid XFER_LAT clocks after the write is sampled. After that, word 0 reads 0 and the captured BSN is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps | input | 1 | Pulse-per-second time reference, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one clock after reg_rd |
| st_valid | output | 1 | Stream valid, high on every clock while running |
| st_sob | output | 1 | Start of block |
| st_eob | output | 1 | End of block |
| st_sync | output | 1 | Sync marker, high only together with st_sob |
| st_bsn | output | 64 | Block sequence number of the current block |

## Verification
A control write sampled at one edge changes the stream at the edge XFER_LAT clocks later. The bench therefore samples on falling edges, confirms that the output is still idle one sample before that edge, and indexes its model time from the first sample after it. Read data is due one edge after the read strobe and is taken at the next falling edge. For an armed start, the rising pps edge sampled at edge P starts the stream at edge P plus the offset, so the samples after P, P+1 and P+2 must be idle and the sample after P+3 must show the first block. Per-clock framing and sync are compared against a model that derives start-of-block, end-of-block, BSN and sync purely from elapsed time, period and block length.

// File: rtl/bsn_stream_src.sv
module bsn_stream_src #(
  parameter int unsigned BLK_CLKS      = 100,
  parameter int unsigned SYNC_CLKS_DEF = 200_000_000,
  parameter int unsigned XFER_LAT      = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pps,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        st_valid,
  output logic        st_sob,
  output logic        st_eob,
  output logic        st_sync,
  output logic [63:0] st_bsn
);

  localparam int BW = (BLK_CLKS > 1) ? $clog2(BLK_CLKS) : 1;
  localparam int XW = $clog2(XFER_LAT + 2);
  localparam logic [BW-1:0] BLK_LAST = BW'(BLK_CLKS - 1);

  typedef enum logic [1:0] {S_OFF, S_ARM, S_WAIT, S_RUN} state_t;

  // register side
  logic [31:0] lo_stage, per_mm, ofs_mm;
  logic [63:0] init_mm;
  logic [1:0]  cmd_mm;
  logic        cmd_pend;
  logic [XW-1:0] xfer_cnt;
  logic        xfer_go;

  // stream side
  state_t      state;
  logic [1:0]  mode_st;
  logic [31:0] per_st, ofs_st, wcnt, clk_cnt;
  logic [63:0] init_st, bsn, cap;
  logic [BW-1:0] blk_cnt;
  logic        due, pps_q;

  logic        running, pps_rise, cmd_now, start, boundary, wrap;
  logic [63:0] init_use;

  assign xfer_go  = (xfer_cnt == XW'(1));
  assign cmd_now  = xfer_go && cmd_pend;
  assign running  = (state == S_RUN);
  assign pps_rise = pps && !pps_q;
  assign init_use = xfer_go ? init_mm : init_st;
  assign boundary = (clk_cnt == 32'd0);
  assign wrap     = ({1'b0, clk_cnt} + 33'd1) >= {1'b0, per_st};

  assign st_valid = running;
  assign st_sob   = running && (blk_cnt == '0);
  assign st_eob   = running && (blk_cnt == BLK_LAST);
  assign st_sync  = st_sob && (due || boundary);
  assign st_bsn   = bsn;

  assign start = (cmd_now && cmd_mm == 2'd1)
              || (!cmd_now && state == S_ARM && pps_rise && ofs_st == 32'd0)
              || (!cmd_now && state == S_WAIT && wcnt == 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_stage <= '0;
      init_mm  <= '0;
      per_mm   <= SYNC_CLKS_DEF;
      ofs_mm   <= '0;
      cmd_mm   <= '0;
      cmd_pend <= 1'b0;
      xfer_cnt <= '0;
    end else begin
      if (xfer_cnt != '0) xfer_cnt <= xfer_cnt - XW'(1);
      if (xfer_go) cmd_pend <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: begin cmd_mm <= reg_wdata[1:0]; cmd_pend <= 1'b1; xfer_cnt <= XW'(XFER_LAT); end
          3'd1: begin per_mm <= reg_wdata; xfer_cnt <= XW'(XFER_LAT); end
          3'd2: lo_stage <= reg_wdata;
          3'd3: begin init_mm <= {reg_wdata, lo_stage}; xfer_cnt <= XW'(XFER_LAT); end
          3'd4: begin ofs_mm <= reg_wdata; xfer_cnt <= XW'(XFER_LAT); end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_OFF;
      mode_st <= '0;
      per_st  <= SYNC_CLKS_DEF;
      ofs_st  <= '0;
      init_st <= '0;
      wcnt    <= '0;
      clk_cnt <= '0;
      blk_cnt <= '0;
      bsn     <= '0;
      cap     <= '0;
      due     <= 1'b0;
      pps_q   <= 1'b0;
    end else begin
      pps_q <= pps;
      if (xfer_go) begin
        per_st  <= per_mm;
        ofs_st  <= ofs_mm;
        init_st <= init_mm;
      end
      if (running) begin
        blk_cnt <= st_eob ? '0 : blk_cnt + BW'(1);
        if (st_eob) bsn <= bsn + 64'd1;
        clk_cnt <= wrap ? 32'd0 : clk_cnt + 32'd1;
        if (st_sync) begin
          cap <= bsn;
          due <= 1'b0;
        end else if (boundary) begin
          due <= 1'b1;
        end
      end
      if (cmd_now) begin
        case (cmd_mm)
          2'd1:    begin state <= S_RUN; mode_st <= 2'd1; end
          2'd2:    begin state <= S_ARM; mode_st <= 2'd2; end
          default: begin state <= S_OFF; mode_st <= 2'd0; end
        endcase
      end else begin
        case (state)
          S_ARM:  if (pps_rise) begin
                    if (ofs_st == 32'd0) state <= S_RUN;
                    else begin state <= S_WAIT; wcnt <= ofs_st; end
                  end
          S_WAIT: if (wcnt == 32'd1) state <= S_RUN;
                  else wcnt <= wcnt - 32'd1;
          default: ;
        endcase
      end
      if (start) begin
        blk_cnt <= '0;
        clk_cnt <= '0;
        bsn     <= init_use;
        due     <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        3'd0:    reg_rdata <= {29'd0, running, mode_st};
        3'd1:    reg_rdata <= per_mm;
        3'd2:    reg_rdata <= cap[31:0];
        3'd3:    reg_rdata <= cap[63:32];
        3'd4:    reg_rdata <= ofs_mm;
        default: reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/bsn_stream_src_chk.sv
module bsn_stream_src_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid,
  input logic        sob,
  input logic        eob,
  input logic        sync,
  input logic [63:0] bsn
);

  a_r2_start_marks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> (sob && sync));

  a_r3_sob_after_eob: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && eob) |=> (!valid || sob));

  a_r3_bsn_step: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && eob) |=> (!valid || sync || bsn == $past(bsn) + 64'd1));

  a_r3_bsn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !eob) |=> (!valid || sob || $stable(bsn)));

endmodule

bind bsn_stream_src bsn_stream_src_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .valid (st_valid),
  .sob   (st_sob),
  .eob   (st_eob),
  .sync  (st_sync),
  .bsn   (st_bsn)
);

// File: tb/sim_bsn_stream_src.sv
module sim_bsn_stream_src;
  localparam int BLK = 10;
  localparam int DEF = 40;
  localparam int LAT = 2;
  localparam int NV  = 4;
  localparam int               V_PER [NV] = '{50, 25, 10, 37};
  localparam int               V_N   [NV] = '{180, 150, 60, 200};
  localparam longint unsigned  V_INIT[NV] = '{64'd7, 64'h1_FFFF_FFFE, 64'd100, 64'hABCD_0000_0000_0005};

  logic clk = 0, rst_n = 0, pps = 0, reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic st_valid, st_sob, st_eob, st_sync;
  logic [63:0] st_bsn;
  int total = 0, bad = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  bsn_stream_src #(.BLK_CLKS(BLK), .SYNC_CLKS_DEF(DEF), .XFER_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .pps(pps), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .st_valid(st_valid), .st_sob(st_sob), .st_eob(st_eob), .st_sync(st_sync), .st_bsn(st_bsn));

  task automatic chk(bit ok, string tag, longint unsigned act, longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    longint unsigned lastcap, ebsn, cur_init;
    int e_frame, e_sync, e_stop, cnt;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!st_valid && !st_sob && !st_eob && !st_sync, "R1 outputs", {st_valid, st_sob, st_eob, st_sync}, 0);
    rd(3'd0, d); chk(d == 0, "R1 status", d, 0);
    rd(3'd1, d); chk(d == DEF, "R1 period", d, DEF);
    rd(3'd2, d); chk(d == 0, "R1 bsn lo", d, 0);
    rd(3'd4, d); chk(d == 0, "R1 offset", d, 0);

    for (int v = 0; v < NV; v++) begin
      wr(3'd2, V_INIT[v][31:0]);
      wr(3'd3, V_INIT[v][63:32]);
      wr(3'd1, V_PER[v]);
      rd(3'd1, d); chk(d == V_PER[v], "R9 period readback", d, V_PER[v]);
      wr(3'd0, 32'd1);
      repeat (LAT - 1) @(negedge clk);
      chk(!st_valid, "R2 not before latency", st_valid, 0);
      @(negedge clk);
      e_frame = 0; e_sync = 0; e_stop = 0; lastcap = 0;
      for (int t = 0; t <= V_N[v] + LAT + 1; t++) begin
        if (t <= V_N[v] + LAT) begin
          bit esob, eeob, esync;
          esob  = (t % BLK) == 0;
          eeob  = (t % BLK) == BLK - 1;
          ebsn  = V_INIT[v] + longint'(t / BLK);
          esync = esob && (t == 0 || (t / V_PER[v]) != ((t - BLK) / V_PER[v]));
          if (esync) lastcap = ebsn;
          if (!st_valid || st_sob != esob || st_eob != eeob || st_bsn != ebsn) e_frame++;
          if (st_sync != esync) e_sync++;
        end else if (st_valid) e_stop++;
        if (t == V_N[v]) begin reg_wr = 1; reg_addr = 3'd0; reg_wdata = 32'd0; end
        if (t == V_N[v] + 1) reg_wr = 0;
        @(negedge clk);
      end
      chk(e_frame == 0, "R3 framing and BSN", e_frame, 0);
      if (V_PER[v] % BLK == 0) chk(e_sync == 0, "R4 sync period", e_sync, 0);
      else                     chk(e_sync == 0, "R5 sync at first sob after boundary", e_sync, 0);
      chk(e_stop == 0, "R10 stop after latency", e_stop, 0);
      rd(3'd2, d); chk(d == lastcap[31:0], "R7 captured lo", d, lastcap[31:0]);
      rd(3'd3, d); chk(d == lastcap[63:32], "R7 captured hi", d, lastcap[63:32]);
      rd(3'd0, d); chk(d == 0, "R10 status off", d, 0);
    end

    // R6 low word stages only
    cur_init = V_INIT[NV-1];
    wr(3'd2, 32'h55);
    wr(3'd0, 32'd1);
    repeat (LAT) @(negedge clk);
    chk(st_valid && st_bsn == cur_init, "R6 lo write alone", st_bsn, cur_init);
    wr(3'd0, 32'd0);
    repeat (LAT + 1) @(negedge clk);
    wr(3'd3, 32'h12);
    wr(3'd0, 32'd1);
    repeat (LAT) @(negedge clk);
    cur_init = 64'h12_0000_0055;
    chk(st_valid && st_bsn == cur_init, "R6 hi write commits", st_bsn, cur_init);
    wr(3'd0, 32'd0);
    repeat (LAT + 1) @(negedge clk);

    // R8 start at pps with offset 3
    wr(3'd4, 32'd3);
    wr(3'd0, 32'd2);
    repeat (LAT + 1) @(negedge clk);
    rd(3'd0, d); chk(d == 2, "R9 status armed", d, 2);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      if (st_valid) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R8 idle without pps edge", cnt, 0);
    pps = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 1) pps = 0;
      if (k < 3) chk(!st_valid, "R8 not before offset", st_valid, 0);
      else chk(st_valid && st_sob && st_sync && st_bsn == cur_init, "R8 start at offset", st_bsn, cur_init);
    end
    rd(3'd0, d); chk(d == 6, "R9 status running at pps", d, 6);
    rd(3'd4, d); chk(d == 3, "R9 offset readback", d, 3);
    wr(3'd0, 32'd0);
    repeat (LAT + 1) @(negedge clk);
    chk(!st_valid, "R10 stopped", st_valid, 0);
    rd(3'd2, d); chk(d == cur_init[31:0], "R7 capture after pps start", d, cur_init[31:0]);
    finish_run();
  end
endmodule